// File: doc/BRIEF.md
# Keyed Paged Address Mapper

The mapper turns a 16-bit word address into a 20-bit physical address. A 4-bit address-state value picks one of sixteen page groups. Each group has a data bank and a program bank of sixteen page entries each. The top four bits of the logical address select one entry in the chosen bank. That entry supplies an 8-bit frame number, which forms the upper part of the physical address. The low twelve bits of the logical address pass through unchanged.

Each page entry also holds a 4-bit key, a write-protect bit and an execute-protect bit. The mapper compares the requester's 4-bit mode with the key of the selected entry. It also checks the access type against the two protection bits. Any violation raises `fault` and holds back the memory strobe.

A request is captured on a clock edge. The translation and the fault decision then come from that captured request through logic alone. Page entries are loaded through a write port indexed by group, bank and entry.

Top module: `pagemap_xlat`

## Requirements
- R1: After a synchronous active-low reset, `fault` and `mem_strobe` are low. Every page entry in every group and bank holds frame 0, key 0 and no protection, so a mode-0 request maps to `{8'h00, addr[11:0]}` without fault.
- R2: A request presented with `req_valid` high is captured at a rising edge, and its translation, fault and strobe appear during the following cycle. When `req_valid` was low at that edge, `fault` and `mem_strobe` are low.
- R3: `req_as` selects which of the sixteen page groups is used. The same logical address under different address states maps through different entries.
- R4: `req_addr[15:12]` selects the entry inside the chosen bank, and that entry's frame drives `phys_addr[19:12]`.
- R5: `phys_addr[11:0]` equals `req_addr[11:0]` of the captured request.
- R6: `req_kind` is encoded as 0 = instruction fetch, 1 = read, 2 = write and 3 = read. A fetch uses the program bank (`cfg_bank` = 1). All other kinds use the data bank (`cfg_bank` = 0).
- R7: Mode 0 passes the key check for every key. Modes 1 to 14 pass only when the key equals the mode or equals 15. Mode 15 passes only when the key is 15. A failed key check raises `fault`.
- R8: A write (kind 2) to an entry with write-protect set raises `fault`. Reads and fetches are not affected by write-protect.
- R9: A fetch (kind 0) from an entry with execute-protect set raises `fault`. Reads and writes are not affected by execute-protect.
- R10: `mem_strobe` is high exactly when a captured request is valid and has no fault.
- R11: A page-entry write and a request captured at the same edge interact as follows: the request is translated and checked using the newly written entry.
- R12: A page-entry write changes only the entry addressed by `cfg_group`, `cfg_bank` and `cfg_entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access type: 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Logical word address |
| req_as | input | 4 | Address state, picks the page group |
| req_mode | input | 4 | Requester mode for the key check |
| cfg_we | input | 1 | Page-entry write enable |
| cfg_group | input | 4 | Group of the entry written |
| cfg_bank | input | 1 | Bank of the entry written: 0 data, 1 program |
| cfg_entry | input | 4 | Entry index inside the bank |
| cfg_frame | input | 8 | Frame number to store |
| cfg_key | input | 4 | Access key to store |
| cfg_wprot | input | 1 | Write-protect bit to store |
| cfg_xprot | input | 1 | Execute-protect bit to store |
| phys_addr | output | 20 | Translated physical address |
| fault | output | 1 | Key or protection violation for the captured request |
| mem_strobe | output | 1 | Memory access permitted for the captured request |

## Verification
The case where two functions fall in the same cycle is a page-entry rewrite landing at the same edge that captures a request. That request must see the new entry, both for its frame number and for its key and protection checks. The bench drives both ports in one cycle, aimed at the very entry the request uses. Some of these writes change the frame, and others flip the key or a protect bit so the fault outcome reverses. A behavioural reference model applies the write before it evaluates the request, and the bench compares address, fault and strobe with that model on every clock. A long random phase mixes writes and requests freely so that these collisions also happen by chance.

// File: rtl/pagemap_pkg.sv
// Shared types for the paged address mapper.
// Assumes a 2-bit access kind; code 3 is an alias of a data read.
package pagemap_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READX = 2'd3
    } acc_kind_t;

    localparam logic BANK_DATA = 1'b0;
    localparam logic BANK_PROG = 1'b1;
endpackage

// File: rtl/pagemap_regfile.sv
// Page-entry storage: groups x two banks x entries.
// One synchronous write port and one combinational read port.
// Assumes the read index is stable for the cycle; a write is visible
// on the read port from the cycle after its edge.
module pagemap_regfile #(
    parameter int GROUP_W = 4,
    parameter int ENTRY_W = 4,
    parameter int FRAME_W = 8,
    parameter int KEY_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [GROUP_W+ENTRY_W:0]          wr_idx,
    input  logic [FRAME_W+KEY_W+1:0]          wr_data,
    input  logic [GROUP_W+ENTRY_W:0]          rd_idx,
    output logic [FRAME_W+KEY_W+1:0]          rd_data
);
    localparam int IDX_W = GROUP_W + ENTRY_W + 1;
    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = FRAME_W + KEY_W + 2;

    logic [ENT_W-1:0] mem [DEPTH];

    // Clear every entry on reset, else store the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Return the entry chosen by the captured request.
    always_comb begin
        rd_data = mem[rd_idx];
    end
endmodule

// File: rtl/pagemap_keychk.sv
// Key and protection check for one captured request.
// Assumes mode 0 is the supervisor and the all-ones value is both the
// unprivileged mode and the shared key. Pure logic; the clock and reset
// are used only by the assertions.
module pagemap_keychk
    import pagemap_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  acc_kind_t        kind,
    input  logic [KEY_W-1:0] mode,
    input  logic [KEY_W-1:0] key,
    input  logic             wprot,
    input  logic             xprot,
    output logic             fault
);
    localparam logic [KEY_W-1:0] KEY_SHARED = {KEY_W{1'b1}};

    logic key_ok;
    logic prot_hit;

    // Decide whether the mode may touch a page with this key.
    always_comb begin
        key_ok = (mode == '0) || (key == KEY_SHARED) || (key == mode);
    end

    // Flag a write to a write-protected page or a fetch from an execute-protected one.
    always_comb begin
        prot_hit = ((kind == ACC_WRITE) && wprot) || ((kind == ACC_FETCH) && xprot);
    end

    // Combine both checks for a live request.
    always_comb begin
        fault = valid && (!key_ok || prot_hit);
    end

    // R7
    sup_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == '0 && kind == ACC_READ) |-> !fault);
    // R7
    unpriv_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == KEY_SHARED && key != KEY_SHARED) |-> fault);
    // R8
    wprot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == ACC_WRITE && wprot) |-> fault);
    // R9
    xprot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == ACC_FETCH && xprot) |-> fault);
endmodule

// File: rtl/pagemap_xlat.sv
// Top of the paged address mapper. Captures a request, looks up the page
// entry for {address state, bank, top address bits}, forms the physical
// address and raises a fault on key or protection violations.
// Assumes outputs are consumed in the cycle after the request edge.
module pagemap_xlat
    import pagemap_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int GROUP_W = 4,
    parameter int ENTRY_W = 4,
    parameter int FRAME_W = 8,
    parameter int KEY_W   = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [1:0]                           req_kind,
    input  logic [LADDR_W-1:0]                   req_addr,
    input  logic [GROUP_W-1:0]                   req_as,
    input  logic [KEY_W-1:0]                     req_mode,
    input  logic                                 cfg_we,
    input  logic [GROUP_W-1:0]                   cfg_group,
    input  logic                                 cfg_bank,
    input  logic [ENTRY_W-1:0]                   cfg_entry,
    input  logic [FRAME_W-1:0]                   cfg_frame,
    input  logic [KEY_W-1:0]                     cfg_key,
    input  logic                                 cfg_wprot,
    input  logic                                 cfg_xprot,
    output logic [FRAME_W+LADDR_W-ENTRY_W-1:0]   phys_addr,
    output logic                                 fault,
    output logic                                 mem_strobe
);
    localparam int OFFS_W = LADDR_W - ENTRY_W;
    localparam int IDX_W  = GROUP_W + ENTRY_W + 1;
    localparam int ENT_W  = FRAME_W + KEY_W + 2;

    logic               valid_q;
    acc_kind_t          kind_q;
    logic [LADDR_W-1:0] addr_q;
    logic [GROUP_W-1:0] as_q;
    logic [KEY_W-1:0]   mode_q;

    logic               bank_sel;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [ENT_W-1:0]   wr_data;
    logic [ENT_W-1:0]   rd_data;
    logic [FRAME_W-1:0] ent_frame;
    logic [KEY_W-1:0]   ent_key;
    logic               ent_wp;
    logic               ent_xp;
    logic               chk_fault;

    // Capture the incoming request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= ACC_FETCH;
            addr_q  <= '0;
            as_q    <= '0;
            mode_q  <= '0;
        end else begin
            valid_q <= req_valid;
            kind_q  <= acc_kind_t'(req_kind);
            addr_q  <= req_addr;
            as_q    <= req_as;
            mode_q  <= req_mode;
        end
    end

    // Pick the bank and form the read index of the captured request.
    always_comb begin
        bank_sel = (kind_q == ACC_FETCH) ? BANK_PROG : BANK_DATA;
        rd_idx   = {as_q, bank_sel, addr_q[LADDR_W-1 -: ENTRY_W]};
    end

    // Pack the write port into an index and an entry word.
    always_comb begin
        wr_idx  = {cfg_group, cfg_bank, cfg_entry};
        wr_data = {cfg_frame, cfg_key, cfg_wprot, cfg_xprot};
    end

    pagemap_regfile #(
        .GROUP_W (GROUP_W),
        .ENTRY_W (ENTRY_W),
        .FRAME_W (FRAME_W),
        .KEY_W   (KEY_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Split the selected entry into its fields.
    always_comb begin
        {ent_frame, ent_key, ent_wp, ent_xp} = rd_data;
    end

    pagemap_keychk #(
        .KEY_W (KEY_W)
    ) u_keychk (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid_q),
        .kind  (kind_q),
        .mode  (mode_q),
        .key   (ent_key),
        .wprot (ent_wp),
        .xprot (ent_xp),
        .fault (chk_fault)
    );

    // Drive the outputs from the frame, the offset and the check result.
    always_comb begin
        phys_addr  = {ent_frame, addr_q[OFFS_W-1:0]};
        fault      = chk_fault;
        mem_strobe = valid_q && !chk_fault;
    end

    // R5
    offs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> phys_addr[OFFS_W-1:0] == $past(req_addr[OFFS_W-1:0]));
    // R10
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> ($past(req_valid) && !fault));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!fault && !mem_strobe));
endmodule

// File: tb/pagemap_xlat_bench.sv
module pagemap_xlat_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_as = '0;
    logic [3:0]  req_mode = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_group = '0;
    logic        cfg_bank = 1'b0;
    logic [3:0]  cfg_entry = '0;
    logic [7:0]  cfg_frame = '0;
    logic [3:0]  cfg_key = '0;
    logic        cfg_wprot = 1'b0;
    logic        cfg_xprot = 1'b0;
    logic [19:0] phys_addr;
    logic        fault;
    logic        mem_strobe;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    cmp_en = 1'b0;
    bit    ended = 1'b0;

    // Behavioural model state: table entries as {frame, key, wp, xp}.
    logic [13:0] rtab [512];
    logic [19:0] e_phys = '0;
    logic        e_fault = 1'b0;
    logic        e_strobe = 1'b0;

    pagemap_xlat u_pagemap_xlat (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_kind (req_kind), .req_addr (req_addr),
        .req_as (req_as), .req_mode (req_mode),
        .cfg_we (cfg_we), .cfg_group (cfg_group), .cfg_bank (cfg_bank),
        .cfg_entry (cfg_entry), .cfg_frame (cfg_frame), .cfg_key (cfg_key),
        .cfg_wprot (cfg_wprot), .cfg_xprot (cfg_xprot),
        .phys_addr (phys_addr), .fault (fault), .mem_strobe (mem_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: apply the entry write first (R11), then evaluate the request.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) rtab[i] = '0;
            e_phys = '0; e_fault = 1'b0; e_strobe = 1'b0;
        end else begin
            int          idx;
            logic [13:0] ent;
            bit          ok;
            bit          f;
            if (cfg_we) rtab[cfg_group*32 + cfg_bank*16 + cfg_entry] = {cfg_frame, cfg_key, cfg_wprot, cfg_xprot};
            idx = req_as*32 + ((req_kind == 2'd0) ? 16 : 0) + req_addr[15:12];
            ent = rtab[idx];
            ok  = (req_mode == 4'd0) || (ent[5:2] == 4'd15) || (ent[5:2] == req_mode);
            f   = req_valid && (!ok || (req_kind == 2'd2 && ent[1]) || (req_kind == 2'd0 && ent[0]));
            e_phys = {ent[13:6], req_addr[11:0]};
            e_fault = f;
            e_strobe = req_valid && !f;
        end
    end

    // Compare against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (cmp_en && !ended) begin
            n_cmp++;
            if (phys_addr !== e_phys || fault !== e_fault || mem_strobe !== e_strobe) begin
                n_bad++;
                $display("FAIL %s phys=%h/%h fault=%b/%b strobe=%b/%b (actual/expected)",
                         tag, phys_addr, e_phys, fault, e_fault, mem_strobe, e_strobe);
            end
        end
    end

    task automatic do_req(input logic [1:0] k, input logic [15:0] a, input logic [3:0] s, input logic [3:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_as = s; req_mode = m; cfg_we = 1'b0;
    endtask

    task automatic do_cfg(input logic [3:0] g, input logic b, input logic [3:0] e, input logic [7:0] fr,
                          input logic [3:0] ky, input logic wp, input logic xp);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b1;
        cfg_group = g; cfg_bank = b; cfg_entry = e; cfg_frame = fr; cfg_key = ky; cfg_wprot = wp; cfg_xprot = xp;
    endtask

    task automatic do_both(input logic [1:0] k, input logic [15:0] a, input logic [3:0] s, input logic [3:0] m,
                           input logic [7:0] fr, input logic [3:0] ky, input logic wp, input logic xp);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_as = s; req_mode = m;
        cfg_we = 1'b1; cfg_group = s; cfg_bank = (k == 2'd0); cfg_entry = a[15:12];
        cfg_frame = fr; cfg_key = ky; cfg_wprot = wp; cfg_xprot = xp;
    endtask

    task automatic do_idle();
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        cmp_en = 1'b1;
        repeat (3) @(posedge clk);
        // R1: reset state, then mode-0 requests through the cleared table.
        tag = "R1";
        @(negedge clk); rst_n = 1'b1;
        do_idle();
        do_req(2'd1, 16'h5a3c, 4'd9, 4'd0);
        do_req(2'd0, 16'hf001, 4'd15, 4'd0);
        do_req(2'd2, 16'h0fff, 4'd0, 4'd0);
        // R2: idle cycles between requests stay quiet.
        tag = "R2";
        do_idle();
        do_req(2'd1, 16'h1234, 4'd1, 4'd0);
        do_idle();
        // R3: same address, different groups.
        tag = "R3";
        do_cfg(4'd3, 1'b0, 4'd7, 8'h33, 4'd0, 1'b0, 1'b0);
        do_cfg(4'd12, 1'b0, 4'd7, 8'hc4, 4'd0, 1'b0, 1'b0);
        do_req(2'd1, 16'h7abc, 4'd3, 4'd0);
        do_req(2'd1, 16'h7abc, 4'd12, 4'd0);
        do_req(2'd1, 16'h7abc, 4'd5, 4'd0);
        // R4 and R5: entry selection by top bits, offset passes through.
        tag = "R4";
        do_cfg(4'd3, 1'b0, 4'd0, 8'h01, 4'd0, 1'b0, 1'b0);
        do_cfg(4'd3, 1'b0, 4'd15, 8'hfe, 4'd0, 1'b0, 1'b0);
        do_req(2'd1, 16'h0123, 4'd3, 4'd0);
        do_req(2'd1, 16'hf456, 4'd3, 4'd0);
        tag = "R5";
        do_req(2'd2, 16'h7000, 4'd3, 4'd0);
        do_req(2'd2, 16'h7fff, 4'd3, 4'd0);
        // R6: program bank for fetches, data bank otherwise, kind 3 is a read.
        tag = "R6";
        do_cfg(4'd6, 1'b1, 4'd2, 8'haa, 4'd0, 1'b0, 1'b0);
        do_cfg(4'd6, 1'b0, 4'd2, 8'h55, 4'd0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) do_req(k[1:0], 16'h2468, 4'd6, 4'd0);
        // R7: key sweep over all modes.
        tag = "R7";
        foreach (rtab[i]) begin end
        for (int kk = 0; kk < 4; kk++) begin
            logic [3:0] ky;
            ky = (kk == 0) ? 4'd0 : (kk == 1) ? 4'd5 : (kk == 2) ? 4'd14 : 4'd15;
            do_cfg(4'd2, 1'b0, 4'd3, 8'h20 + 8'(kk), ky, 1'b0, 1'b0);
            for (int m = 0; m < 16; m++) do_req(2'd1, 16'h3abc, 4'd2, m[3:0]);
        end
        // R8: write protection.
        tag = "R8";
        do_cfg(4'd4, 1'b0, 4'd9, 8'h49, 4'd0, 1'b1, 1'b0);
        do_cfg(4'd4, 1'b1, 4'd9, 8'h94, 4'd0, 1'b1, 1'b0);
        do_req(2'd2, 16'h9000, 4'd4, 4'd0);
        do_req(2'd1, 16'h9001, 4'd4, 4'd0);
        do_req(2'd0, 16'h9002, 4'd4, 4'd0);
        // R9: execute protection.
        tag = "R9";
        do_cfg(4'd4, 1'b1, 4'd10, 8'ha4, 4'd0, 1'b0, 1'b1);
        do_cfg(4'd4, 1'b0, 4'd10, 8'h4a, 4'd0, 1'b0, 1'b1);
        do_req(2'd0, 16'ha000, 4'd4, 4'd0);
        do_req(2'd1, 16'ha001, 4'd4, 4'd0);
        do_req(2'd2, 16'ha002, 4'd4, 4'd0);
        // R10: strobe against fault with back-to-back mixed requests.
        tag = "R10";
        do_req(2'd2, 16'h9abc, 4'd4, 4'd0);
        do_req(2'd1, 16'h9abc, 4'd4, 4'd0);
        do_req(2'd1, 16'h3abc, 4'd2, 4'd7);
        do_idle();
        // R11: entry write and request on the same edge to the same entry.
        tag = "R11";
        do_both(2'd1, 16'hb111, 4'd8, 4'd0, 8'h81, 4'd0, 1'b0, 1'b0);
        do_both(2'd1, 16'hb222, 4'd8, 4'd6, 8'h82, 4'd6, 1'b0, 1'b0);
        do_both(2'd1, 16'hb333, 4'd8, 4'd6, 8'h83, 4'd9, 1'b0, 1'b0);
        do_both(2'd2, 16'hb444, 4'd8, 4'd0, 8'h84, 4'd0, 1'b1, 1'b0);
        do_both(2'd0, 16'hc555, 4'd8, 4'd0, 8'h85, 4'd0, 1'b0, 1'b1);
        do_both(2'd0, 16'hc666, 4'd8, 4'd0, 8'h86, 4'd0, 1'b0, 1'b0);
        // R12: random mix of writes and requests.
        tag = "R12";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            req_valid = ($urandom_range(0, 3) != 0);
            req_kind  = 2'($urandom_range(0, 3));
            req_addr  = 16'($urandom);
            req_as    = 4'($urandom_range(0, 3));
            req_mode  = 4'($urandom_range(0, 15));
            cfg_we    = ($urandom_range(0, 2) == 0);
            cfg_group = 4'($urandom_range(0, 3));
            cfg_bank  = 1'($urandom_range(0, 1));
            cfg_entry = 4'($urandom_range(0, 15));
            cfg_frame = 8'($urandom);
            cfg_key   = ($urandom_range(0, 1) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
            cfg_wprot = ($urandom_range(0, 3) == 0);
            cfg_xprot = ($urandom_range(0, 3) == 0);
        end
        do_idle();
        do_idle();
        @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end
endmodule